// File: doc/BRIEF.md
# Power-Mode-Aware System Clock Source Selector

This block picks which of four clock sources drives the system clock: an external oscillator, a slow internal oscillator, a fast internal oscillator or a PLL. Software programs a separate 4-bit source choice for each of three run power modes: normal, low-power and high-speed. The block follows the power-mode input and always acts on the choice held for the mode in force, so a mode change needs no further register writes.

A change of source takes effect only when the target source reports both its enable bit and its valid flag. A choice that the current mode forbids is refused, and so is an unknown code. In either case the source already in use stays selected. The result is a registered one-hot select for an external glitch-free clock mux. A status register reports the code of the source in effect, so software can poll it to confirm a switch. If the valid flag of the active source drops, the selection is held and a sticky error bit is raised.

Top module: `clksel_top`

## Requirements
- R1: After reset the active source is the slow internal oscillator (code 0x2, select bit 1), all three per-mode registers read 0x2 and the error bit is 0.
- R2: Source codes are 0x1 = external oscillator (select bit 0), 0x2 = slow internal (bit 1), 0x3 = fast internal (bit 2) and 0x6 = PLL (bit 3).
- R3: The mode input picks the register that is applied: 0 = normal (address 1), 1 = low-power (address 2), 2 = high-speed (address 3). Mode 3 is treated as normal. The register holds its code in bits [3:0]; all other bits read 0.
- R4: A switch to the requested source happens on the clock edge after a cycle in which that source's enable and valid inputs are both 1. Until then the previous source stays active.
- R5: In low-power mode, a request for the fast internal oscillator or the PLL is ignored.
- R6: In low-power mode, a request for the slow internal oscillator also needs the slow low-power enable input to be 1.
- R7: Codes other than 0x1, 0x2, 0x3 and 0x6 are ignored and leave the active source unchanged.
- R8: A per-mode register is written only when all four byte strobes are set. Narrower writes leave it unchanged.
- R9: Address 0 reads as status: bits [3:0] hold the active source code and bit 8 holds the error bit. All other bits read 0.
- R10: The error bit is set on the edge after any cycle in which the active source's valid flag is 0, and it stays set. A write to address 0 with byte strobe 1 set and data bit 8 = 1 clears it. A set in the same cycle takes priority over a clear.
- R11: The select output is always one-hot and matches the status code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_mode | input | 2 | Run power mode: 0 normal, 1 low-power, 2 high-speed, 3 as normal |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_be | input | 4 | Byte strobes of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_en | input | 4 | Enable bit of each source (bit order as in R2) |
| src_vld | input | 4 | Valid flag of each source |
| slow_lp_en | input | 1 | Low-power enable of the slow internal oscillator |
| clk_sel | output | 4 | One-hot select for the clock mux |
| src_err | output | 1 | Sticky error bit |

## Verification
Directed sequences first request a source whose enable is low, then raise the enable. This shows that the wait on readiness (R4) is separate from the decode of the code. In low-power mode, requests for the fast oscillator, the PLL and the slow oscillator without its low-power enable are refused; these separate the mode check from the readiness check. Narrow writes and reserved codes confirm that neither touches the registers or the selection. A loss of valid followed by a clear shows that the error bit is sticky and that a set wins over a clear. Seeded random traffic then mixes mode changes, full and partial writes, known and unknown codes, and enable and valid patterns. A bench model checks the read data and the select every cycle, which exposes any wrong per-mode register choice or an early or late switch.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int NSRC   = 4;
  localparam int CODE_W = 4;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int NMODE  = 3;

  localparam logic [CODE_W-1:0] CODE_EXT  = 4'h1;
  localparam logic [CODE_W-1:0] CODE_SLOW = 4'h2;
  localparam logic [CODE_W-1:0] CODE_FAST = 4'h3;
  localparam logic [CODE_W-1:0] CODE_PLL  = 4'h6;

  localparam logic [IDX_W-1:0] IDX_EXT  = 2'd0;
  localparam logic [IDX_W-1:0] IDX_SLOW = 2'd1;
  localparam logic [IDX_W-1:0] IDX_FAST = 2'd2;
  localparam logic [IDX_W-1:0] IDX_PLL  = 2'd3;

  localparam logic [1:0] PM_RUN = 2'd0;
  localparam logic [1:0] PM_LP  = 2'd1;
  localparam logic [1:0] PM_HS  = 2'd2;

  function automatic logic code_known(input logic [CODE_W-1:0] c);
    return (c == CODE_EXT) || (c == CODE_SLOW) || (c == CODE_FAST) || (c == CODE_PLL);
  endfunction

  function automatic logic [IDX_W-1:0] code_to_idx(input logic [CODE_W-1:0] c);
    case (c)
      CODE_EXT:  return IDX_EXT;
      CODE_FAST: return IDX_FAST;
      CODE_PLL:  return IDX_PLL;
      default:   return IDX_SLOW;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] idx_to_code(input logic [IDX_W-1:0] i);
    case (i)
      IDX_EXT:  return CODE_EXT;
      IDX_FAST: return CODE_FAST;
      IDX_PLL:  return CODE_PLL;
      default:  return CODE_SLOW;
    endcase
  endfunction

  // Which per-mode register applies: mode 3 falls back to normal run.
  function automatic logic [1:0] mode_slot(input logic [1:0] m);
    return (m == 2'd3) ? PM_RUN : m;
  endfunction

  function automatic logic mode_allows(input logic [1:0] m, input logic [IDX_W-1:0] i,
                                       input logic lp_en);
    if (m != PM_LP) return 1'b1;
    if (i == IDX_FAST || i == IDX_PLL) return 1'b0;
    if (i == IDX_SLOW) return lp_en;
    return 1'b1;
  endfunction
endpackage

// File: rtl/clksel_regs.sv
module clksel_regs
  import clksel_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wen,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [1:0]          pwr_mode,
  input  logic [CODE_W-1:0]   active_code,
  input  logic                err,
  output logic [DATA_W-1:0]   rdata,
  output logic [CODE_W-1:0]   req_code,
  output logic                err_clr
);
  localparam int BE_W    = DATA_W / 8;
  localparam int ERR_BIT = 8;

  logic [NMODE-1:0][CODE_W-1:0] cfg_q;
  logic full_wr;

  assign full_wr = wen && (be == {BE_W{1'b1}});
  assign err_clr = wen && (addr == '0) && be[ERR_BIT/8] && wdata[ERR_BIT];

  for (genvar m = 0; m < NMODE; m++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[m] <= CODE_SLOW;
      else if (full_wr && (addr == ADDR_W'(m + 1)))
        cfg_q[m] <= wdata[CODE_W-1:0];
    end
  end

  assign req_code = cfg_q[mode_slot(pwr_mode)];

  always_comb begin
    rdata = '0;
    if (addr == '0) begin
      rdata[CODE_W-1:0] = active_code;
      rdata[ERR_BIT]    = err;
    end else if (int'(addr) <= NMODE) begin
      rdata[CODE_W-1:0] = cfg_q[int'(addr) - 1];
    end
  end

  // R8
  narrow_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && (be != {BE_W{1'b1}})) |=> $stable(cfg_q));
endmodule

// File: rtl/clksel_arb.sv
module clksel_arb
  import clksel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pwr_mode,
  input  logic [CODE_W-1:0] req_code,
  input  logic [NSRC-1:0]   src_en,
  input  logic [NSRC-1:0]   src_vld,
  input  logic              slow_lp_en,
  input  logic              err_clr,
  output logic [CODE_W-1:0] active_code,
  output logic [NSRC-1:0]   sel,
  output logic              err
);
  logic [IDX_W-1:0] active_q, act_d, req_idx;
  logic [NSRC-1:0]  sel_q, sel_d, rdy;
  logic             req_known, req_ok, sw_evt, loss_evt, err_q;

  assign rdy       = src_en & src_vld;
  assign req_known = code_known(req_code);
  assign req_idx   = code_to_idx(req_code);
  assign req_ok    = req_known && mode_allows(pwr_mode, req_idx, slow_lp_en) && rdy[req_idx];
  assign sw_evt    = req_ok && (req_idx != active_q);
  assign loss_evt  = !src_vld[active_q];
  assign act_d     = sw_evt ? req_idx : active_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_sel
    assign sel_d[i] = (act_d == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= IDX_SLOW;
      sel_q    <= NSRC'(1) << IDX_SLOW;
      err_q    <= 1'b0;
    end else begin
      active_q <= act_d;
      sel_q    <= sel_d;
      if (loss_evt)     err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign active_code = idx_to_code(active_q);
  assign sel         = sel_q;
  assign err         = err_q;

  // R4
  switch_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_q) |-> (($past(rdy) & sel_q) != '0));

  // R5
  lp_forbid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_mode) == PM_LP && !$stable(active_q)) |-> (sel_q[IDX_FAST] == 1'b0 && sel_q[IDX_PLL] == 1'b0));

  // R7
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_known |=> $stable(active_q));

  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loss_evt |=> err_q);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);

  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_q) == 1);
endmodule

// File: rtl/clksel_top.sv
module clksel_top
  import clksel_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          pwr_mode,
  input  logic                bus_wen,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NSRC-1:0]     src_en,
  input  logic [NSRC-1:0]     src_vld,
  input  logic                slow_lp_en,
  output logic [NSRC-1:0]     clk_sel,
  output logic                src_err
);
  logic [CODE_W-1:0] req_code, active_code;
  logic              err_clr;

  clksel_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(bus_wen), .addr(bus_addr), .be(bus_be),
    .wdata(bus_wdata), .pwr_mode(pwr_mode), .active_code(active_code),
    .err(src_err), .rdata(bus_rdata), .req_code(req_code), .err_clr(err_clr)
  );

  clksel_arb u_arb (
    .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .req_code(req_code),
    .src_en(src_en), .src_vld(src_vld), .slow_lp_en(slow_lp_en),
    .err_clr(err_clr), .active_code(active_code), .sel(clk_sel), .err(src_err)
  );
endmodule

// File: tb/sim_clksel_top.sv
module sim_clksel_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  pwr_mode = 2'd0;
  logic        bus_wen = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_en = 4'hF;
  logic [3:0]  src_vld = 4'hF;
  logic        slow_lp_en = 1'b1;
  logic [3:0]  clk_sel;
  logic        src_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] m_cfg [3];
  int         m_act;
  bit         m_err;

  always #5 clk = ~clk;

  clksel_top u0 (
    .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .bus_wen(bus_wen),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_en(src_en), .src_vld(src_vld),
    .slow_lp_en(slow_lp_en), .clk_sel(clk_sel), .src_err(src_err)
  );

  // R2 encoding, restated: -1 marks a reserved code
  function automatic int b_idx(input logic [3:0] c);
    if (c == 4'd1) return 0;
    if (c == 4'd2) return 1;
    if (c == 4'd3) return 2;
    if (c == 4'd6) return 3;
    return -1;
  endfunction

  function automatic logic [3:0] b_code(input int i);
    logic [3:0] t [4] = '{4'd1, 4'd2, 4'd3, 4'd6};
    return t[i];
  endfunction

  function automatic logic [31:0] b_read(input logic [1:0] a);
    if (a == 2'd0) return {23'd0, m_err, 4'd0, b_code(m_act)};
    return {28'd0, m_cfg[a - 1]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] md, input bit w, input logic [1:0] a,
                      input logic [3:0] be, input logic [31:0] wd, input logic [3:0] en,
                      input logic [3:0] vl, input bit lp, input string tag);
    logic [3:0] req;
    int ri, nact, slot;
    bit ok, nerr;
    pwr_mode = md; bus_wen = w; bus_addr = a; bus_be = be; bus_wdata = wd;
    src_en = en; src_vld = vl; slow_lp_en = lp;
    #1;
    check({tag, " read (R9)"}, bus_rdata, b_read(a));
    slot = (md == 2'd3) ? 0 : int'(md);
    req = m_cfg[slot];
    ri = b_idx(req);
    ok = (ri >= 0);
    if (ok) ok = en[ri] && vl[ri];
    if (ok && md == 2'd1) begin
      if (ri == 2 || ri == 3) ok = 0;
      if (ri == 1 && !lp) ok = 0;
    end
    nact = ok ? ri : m_act;
    nerr = m_err;
    if (!vl[m_act]) nerr = 1;
    else if (w && a == 2'd0 && be[1] && wd[8]) nerr = 0;
    @(posedge clk);
    #1;
    if (w && be == 4'hF && a != 2'd0) m_cfg[a - 1] = wd[3:0];
    m_act = nact;
    m_err = nerr;
    check({tag, " select (R11)"}, {28'd0, clk_sel}, 32'(4'(1) << m_act));
    check({tag, " error"}, {31'd0, src_err}, {31'd0, m_err});
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    for (int k = 0; k < 3; k++) m_cfg[k] = 4'd2;
    m_act = 1; m_err = 0;
    repeat (3) @(negedge clk);
    // R1: reset values observed before release
    #1;
    check("R1 reset select", {28'd0, clk_sel}, 32'h2);
    check("R1 reset error", {31'd0, src_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++)
      step(2'd0, 0, 2'(a), 4'h0, 0, 4'hF, 4'hF, 1, "R1");
    // R2 R4: external oscillator requested while disabled, then enabled
    step(2'd0, 1, 2'd1, 4'hF, 32'h1, 4'b1110, 4'hF, 1, "R2 write");
    step(2'd0, 0, 2'd0, 4'h0, 0, 4'b1110, 4'hF, 1, "R4 not ready");
    check("R4 held on slow", {28'd0, clk_sel}, 32'h2);
    step(2'd0, 0, 2'd0, 4'h0, 0, 4'hF, 4'hF, 1, "R4 ready");
    check("R2 ext code", bus_rdata, 32'h1);
    // R3: low-power register applies in mode 1
    step(2'd0, 1, 2'd2, 4'hF, 32'hFFFF_FFF3, 4'hF, 4'hF, 1, "R3 write lp");
    step(2'd0, 0, 2'd2, 4'h0, 0, 4'hF, 4'hF, 1, "R3 readback");
    check("R3 upper bits zero", bus_rdata, 32'h3);
    // R5: fast oscillator refused in low-power
    step(2'd1, 0, 2'd0, 4'h0, 0, 4'hF, 4'hF, 1, "R5 fast");
    step(2'd1, 0, 2'd0, 4'h0, 0, 4'hF, 4'hF, 1, "R5 fast hold");
    check("R5 still ext", {28'd0, clk_sel}, 32'h1);
    step(2'd1, 1, 2'd2, 4'hF, 32'h6, 4'hF, 4'hF, 1, "R5 pll");
    step(2'd1, 0, 2'd0, 4'h0, 0, 4'hF, 4'hF, 1, "R5 pll hold");
    check("R5 pll refused", {28'd0, clk_sel}, 32'h1);
    // R6: slow oscillator in low-power needs its low-power enable
    step(2'd1, 1, 2'd2, 4'hF, 32'h2, 4'hF, 4'hF, 0, "R6 write");
    step(2'd1, 0, 2'd0, 4'h0, 0, 4'hF, 4'hF, 0, "R6 no lp enable");
    check("R6 held ext", {28'd0, clk_sel}, 32'h1);
    step(2'd1, 0, 2'd0, 4'h0, 0, 4'hF, 4'hF, 1, "R6 lp enable");
    check("R6 on slow", {28'd0, clk_sel}, 32'h2);
    // R3: high-speed and mode 3 use their own registers
    step(2'd2, 1, 2'd3, 4'hF, 32'h6, 4'hF, 4'hF, 1, "R3 hs write");
    step(2'd2, 0, 2'd0, 4'h0, 0, 4'hF, 4'hF, 1, "R3 hs pll");
    check("R3 hs on pll", {28'd0, clk_sel}, 32'h8);
    step(2'd3, 0, 2'd0, 4'h0, 0, 4'hF, 4'hF, 1, "R3 mode3 as normal");
    check("R3 mode3 ext", {28'd0, clk_sel}, 32'h1);
    // R7: reserved code
    step(2'd0, 1, 2'd1, 4'hF, 32'h5, 4'hF, 4'hF, 1, "R7 reserved");
    step(2'd0, 0, 2'd0, 4'h0, 0, 4'hF, 4'hF, 1, "R7 hold");
    check("R7 unchanged", {28'd0, clk_sel}, 32'h1);
    // R8: narrow write discarded
    step(2'd0, 1, 2'd1, 4'h7, 32'h3, 4'hF, 4'hF, 1, "R8 narrow");
    step(2'd0, 0, 2'd1, 4'h0, 0, 4'hF, 4'hF, 1, "R8 readback");
    check("R8 reg kept", bus_rdata, 32'h5);
    // R10: valid loss, sticky, set beats clear, then clear
    step(2'd0, 1, 2'd1, 4'hF, 32'h1, 4'hF, 4'hF, 1, "R10 back to ext");
    step(2'd0, 0, 2'd0, 4'h0, 0, 4'hF, 4'b1110, 1, "R10 loss");
    check("R10 held ext", {28'd0, clk_sel}, 32'h1);
    step(2'd0, 0, 2'd0, 4'h0, 0, 4'hF, 4'hF, 1, "R10 sticky");
    check("R10 status bit", bus_rdata, 32'h101);
    step(2'd0, 1, 2'd0, 4'h2, 32'h100, 4'hF, 4'b1110, 1, "R10 set wins");
    step(2'd0, 1, 2'd0, 4'h2, 32'h100, 4'hF, 4'hF, 1, "R10 clear");
    check("R10 cleared", {31'd0, src_err}, 32'd0);
    // random traffic, R9 and R11 checked against the model every cycle
    for (int n = 0; n < 1500; n++) begin
      logic [3:0] en, vl, nib, be;
      logic [31:0] wd;
      logic [3:0] pick [5] = '{4'd1, 4'd2, 4'd3, 4'd6, 4'd0};
      for (int b = 0; b < 4; b++) begin
        en[b] = ($urandom % 8) != 0;
        vl[b] = ($urandom % 16) != 0;
      end
      nib = pick[$urandom % 5];
      if (nib == 4'd0) nib = 4'($urandom);
      be = (($urandom % 4) == 0) ? 4'($urandom) : 4'hF;
      wd = {$urandom} & 32'hFFFF_FFF0 | 32'(nib);
      step(2'($urandom), ($urandom % 3) == 0, 2'($urandom), be, wd, en, vl,
           ($urandom % 4) != 0, "R9 R11 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule